// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This unit sits between a 32-bit word-addressed register bus and an I2C master engine and its two byte FIFOs. It holds the enable bits, the soft-reset request and the two SCL divider values. It builds a status word from latched engine events, live engine and pin levels, and FIFO flags. It merges the enabled conditions into a single interrupt line. One shared data word links the bus to the FIFOs: a write to it offers a byte to the transmit FIFO, and a read from it takes a byte from the receive FIFO.

Bus requests are single-cycle. `bus_valid` with `bus_write` high is a write and is always accepted. `bus_valid` with `bus_write` low is a read: `bus_rdata` is loaded at that clock edge and `bus_rvalid` is high for exactly the following cycle. Word index `bus_addr` selects the register: data 0, status 1, control 2, SCL-low divider 3, SCL-high divider 4, receive level 6, transmit level 7.

The FIFO sides follow valid/ready rules. The transmit side is never stalled. `tx_valid` is raised for a single cycle, and only when `tx_ready` is high in that cycle. A data write made while `tx_ready` is low is discarded and is not retried. On the receive side, the FIFO holds `rx_valid` and `rx_data`. The unit raises `rx_ready` for one cycle, only during a data read made while `rx_valid` is high, and the byte moves in that cycle.

Top module: `i2c_rf_top`

## Requirements
- R1: After reset, control, both dividers and the latched events are zero, `irq` is low, and status reads 0xA00 when the receive FIFO is empty, the transmit FIFO is not full and the transmit FIFO is empty.
- R2: Control (word 2) reads back the written value masked to 0x1EF. Enables sit at bits 0 done, 1 arbitration lost, 2 no-ack, 3 data request, 5 receive data present, 6 receive full and 7 transmit full. Soft reset is bit 8. All other bits read 0.
- R3: Divider words 3 (SCL low) and 4 (SCL high) keep only the low 10 bits of a write. They read back those 10 bits and drive them on `scl_lo_div` and `scl_hi_div`.
- R4: Status (word 1) has these bits: 0 done, 1 arbitration lost, 2 `eng_nack`, 3 `eng_data_req`, 5 `eng_active`, 6 `scl_in`, 7 `sda_in`, 8 `rx_full`, 9 receive empty (`!rx_valid`), 10 transmit full (`!tx_ready`), 11 `tx_empty`. All other bits read 0.
- R5: Status bits 0 and 1 are set by the `evt_done` and `evt_arb_lost` pulses and stay set until a status write with a 1 in that bit. Writing 0 leaves the bit unchanged. If an event and its clear arrive in the same cycle, the bit stays set.
- R6: Writing 1 to control bit 8 sets `soft_rst`, which reads back as 1 until a `reset_done` pulse clears it. Writing 0 to bit 8 does not clear it.
- R7: `irq` is the OR over the seven enable bits, each ANDed with its condition. The conditions are: done, arbitration lost, no-ack, data request, receive data present (`rx_valid`), `rx_full`, and transmit full.
- R8: A write to word 0 while `tx_ready` is high presents `bus_wdata[7:0]` on `tx_data` with `tx_valid` for that cycle. A write while `tx_ready` is low produces no `tx_valid`.
- R9: A read of word 0 while `rx_valid` is high returns `rx_data` zero-extended and raises `rx_ready` for that cycle. With `rx_valid` low the read returns 0 and does not raise `rx_ready`.
- R10: Word 6 reads `rx_level` and word 7 reads `tx_level`, each zero-extended.
- R11: `bus_rvalid` is high only in the cycle after a read request. Unmapped words read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| evt_done | input | 1 | Engine transfer-done pulse |
| evt_arb_lost | input | 1 | Engine arbitration-lost pulse |
| eng_nack | input | 1 | Engine no-ack level |
| eng_data_req | input | 1 | Engine needs transmit data |
| eng_active | input | 1 | Engine owns the bus |
| scl_in | input | 1 | Live SCL pin |
| sda_in | input | 1 | Live SDA pin |
| reset_done | input | 1 | Engine finished soft reset |
| soft_rst | output | 1 | Soft reset request to engine |
| scl_lo_div | output | 10 | SCL low-phase divider |
| scl_hi_div | output | 10 | SCL high-phase divider |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Transmit FIFO not full |
| tx_data | output | 8 | Transmit byte |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_level | input | 5 | Transmit FIFO fill level |
| rx_valid | input | 1 | Receive FIFO not empty |
| rx_ready | output | 1 | Receive byte taken |
| rx_data | input | 8 | Receive byte at head |
| rx_full | input | 1 | Receive FIFO full |
| rx_level | input | 5 | Receive FIFO fill level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the interrupt line under every mix of enables and conditions. Two of those conditions are latched events that can only be set by engine pulses and only be removed by status writes. The stimulus walks all 128 condition vectors. For each one it first clears both latched bits with a status write, then pulses the needed events and sets the level inputs. It then writes all 128 enable masks in turn and compares `irq` against an OR computed in the bench. An event that lands in the same cycle as its clear is driven on purpose, to show that the event takes precedence.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  // Word indices on the register bus
  localparam int unsigned W_DATA  = 0;
  localparam int unsigned W_STAT  = 1;
  localparam int unsigned W_CTRL  = 2;
  localparam int unsigned W_SCLLO = 3;
  localparam int unsigned W_SCLHI = 4;
  localparam int unsigned W_RXLVL = 6;
  localparam int unsigned W_TXLVL = 7;
  // Status bit positions
  localparam int unsigned S_DONE   = 0;
  localparam int unsigned S_ARB    = 1;
  localparam int unsigned S_NACK   = 2;
  localparam int unsigned S_DREQ   = 3;
  localparam int unsigned S_ACTIVE = 5;
  localparam int unsigned S_SCL    = 6;
  localparam int unsigned S_SDA    = 7;
  localparam int unsigned S_RXFULL = 8;
  localparam int unsigned S_RXEMPT = 9;
  localparam int unsigned S_TXFULL = 10;
  localparam int unsigned S_TXEMPT = 11;
  // Control: soft reset position, number of interrupt sources
  localparam int unsigned C_SRST   = 8;
  localparam int unsigned N_IRQSRC = 7;
  localparam int unsigned N_STICKY = 2;
endpackage

// File: rtl/i2c_rf_sticky.sv
module i2c_rf_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    assert_event_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
    assert_w1c_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl #(
  parameter int EN_W  = 7,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [EN_W-1:0]  en_wdata,
  input  logic             srst_wdata,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             reset_done,
  output logic [EN_W-1:0]  en,
  output logic             srst,
  output logic [DIV_W-1:0] div_lo,
  output logic [DIV_W-1:0] div_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      div_lo <= '0;
      div_hi <= '0;
    end else begin
      if (wr_ctrl) en     <= en_wdata;
      if (wr_lo)   div_lo <= div_wdata;
      if (wr_hi)   div_hi <= div_wdata;
    end
  end

  // Soft reset: a new request takes precedence over the engine's release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     srst <= 1'b0;
    else if (wr_ctrl && srst_wdata) srst <= 1'b1;
    else if (reset_done)            srst <= 1'b0;
  end

  assert_srst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !reset_done) |=> srst);
  assert_srst_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_done && !(wr_ctrl && srst_wdata)) |=> !srst);
  assert_div_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> ($stable(div_lo) && $stable(div_hi)));
endmodule

// File: rtl/i2c_rf_irq.sv
module i2c_rf_irq #(
  parameter int N = 7
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] cond,
  output logic         irq
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = en[i] & cond[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/i2c_rf_top.sv
module i2c_rf_top
  import i2c_rf_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 5,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              evt_done,
  input  logic              evt_arb_lost,
  input  logic              eng_nack,
  input  logic              eng_data_req,
  input  logic              eng_active,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              reset_done,
  output logic              soft_rst,
  output logic [DIV_W-1:0]  scl_lo_div,
  output logic [DIV_W-1:0]  scl_hi_div,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_empty,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_full,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              irq
);
  localparam int EN_W = N_IRQSRC;

  logic wr, rd;
  assign wr = bus_valid &  bus_write;
  assign rd = bus_valid & ~bus_write;

  logic hit_data, hit_stat, hit_ctrl, hit_lo, hit_hi;
  assign hit_data = (bus_addr == ADDR_W'(W_DATA));
  assign hit_stat = (bus_addr == ADDR_W'(W_STAT));
  assign hit_ctrl = (bus_addr == ADDR_W'(W_CTRL));
  assign hit_lo   = (bus_addr == ADDR_W'(W_SCLLO));
  assign hit_hi   = (bus_addr == ADDR_W'(W_SCLHI));

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[31:DIV_W];

  // Latched engine events, write-one-to-clear
  logic [N_STICKY-1:0] ev_q;
  i2c_rf_sticky #(.N(N_STICKY)) u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .set  ({evt_arb_lost, evt_done}),
    .clr  ({2{wr & hit_stat}} & bus_wdata[S_ARB:S_DONE]),
    .q    (ev_q)
  );

  // Control and divider registers; enable bits split around bit 4
  logic [EN_W-1:0] en;
  i2c_rf_ctrl #(.EN_W(EN_W), .DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr & hit_ctrl),
    .wr_lo     (wr & hit_lo),
    .wr_hi     (wr & hit_hi),
    .en_wdata  ({bus_wdata[7:5], bus_wdata[3:0]}),
    .srst_wdata(bus_wdata[C_SRST]),
    .div_wdata (bus_wdata[DIV_W-1:0]),
    .reset_done(reset_done),
    .en        (en),
    .srst      (soft_rst),
    .div_lo    (scl_lo_div),
    .div_hi    (scl_hi_div)
  );

  logic [EN_W-1:0] cond;
  assign cond = {~tx_ready, rx_full, rx_valid, eng_data_req, eng_nack, ev_q[1], ev_q[0]};

  i2c_rf_irq #(.N(EN_W)) u_irq (
    .en  (en),
    .cond(cond),
    .irq (irq)
  );

  // FIFO side: push only when accepted, pop only when present
  assign tx_valid = wr & hit_data & tx_ready;
  assign tx_data  = bus_wdata[DATA_W-1:0];
  assign rx_ready = rd & hit_data & rx_valid;

  logic [31:0] stat_w, ctrl_w;
  always_comb begin
    stat_w           = '0;
    stat_w[S_DONE]   = ev_q[0];
    stat_w[S_ARB]    = ev_q[1];
    stat_w[S_NACK]   = eng_nack;
    stat_w[S_DREQ]   = eng_data_req;
    stat_w[S_ACTIVE] = eng_active;
    stat_w[S_SCL]    = scl_in;
    stat_w[S_SDA]    = sda_in;
    stat_w[S_RXFULL] = rx_full;
    stat_w[S_RXEMPT] = ~rx_valid;
    stat_w[S_TXFULL] = ~tx_ready;
    stat_w[S_TXEMPT] = tx_empty;
    ctrl_w           = '0;
    ctrl_w[3:0]      = en[3:0];
    ctrl_w[7:5]      = en[6:4];
    ctrl_w[C_SRST]   = soft_rst;
  end

  logic [31:0] rmux;
  always_comb begin
    unique case (bus_addr)
      ADDR_W'(W_DATA):  rmux = rx_valid ? 32'(rx_data) : '0;
      ADDR_W'(W_STAT):  rmux = stat_w;
      ADDR_W'(W_CTRL):  rmux = ctrl_w;
      ADDR_W'(W_SCLLO): rmux = 32'(scl_lo_div);
      ADDR_W'(W_SCLHI): rmux = 32'(scl_hi_div);
      ADDR_W'(W_RXLVL): rmux = 32'(rx_level);
      ADDR_W'(W_TXLVL): rmux = 32'(tx_level);
      default:          rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
    end
  end

  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);
  assert_push_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);
  assert_rvalid_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  assert_rvalid_only_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !bus_rvalid);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: tb/sim_i2c_rf_top.sv
`timescale 1ns/1ps
module sim_i2c_rf_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic evt_done = 0, evt_arb_lost = 0, eng_nack = 0, eng_data_req = 0;
  logic eng_active = 0, scl_in = 0, sda_in = 0, reset_done = 0;
  logic soft_rst;
  logic [9:0] scl_lo_div, scl_hi_div;
  logic tx_valid, tx_ready = 1, tx_empty = 1;
  logic [7:0] tx_data;
  logic [4:0] tx_level = '0, rx_level = '0;
  logic rx_valid = 0, rx_ready, rx_full = 0;
  logic [7:0] rx_data = '0;
  logic irq;

  i2c_rf_top u0 (.*);

  int n_chk = 0, n_fail = 0, push_cnt = 0, pop_cnt = 0;
  logic [7:0] last_push = '0;
  bit done_flag = 0;

  always @(posedge clk) begin
    if (tx_valid) begin push_cnt++; last_push = tx_data; end
    if (rx_ready && rx_valid) pop_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    d = bus_rdata;
    chk("R11 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic pulse_events(input logic d, input logic a);
    @(negedge clk); evt_done = d; evt_arb_lost = a;
    @(negedge clk); evt_done = 0; evt_arb_lost = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p0, q0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd(4'd2, d); chk("R1 ctrl", d, 0);
    rd(4'd3, d); chk("R1 sclo", d, 0);
    rd(4'd4, d); chk("R1 sclhi", d, 0);
    rd(4'd1, d); chk("R1 status", d, 32'hA00);
    @(negedge clk); chk("R11 rvalid low after idle", 32'(bus_rvalid), 0);

    // R2 control mask, R6 soft reset
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, d); chk("R2 ctrl mask", d, 32'h1EF);
    chk("R6 srst pin", 32'(soft_rst), 1);
    wr(4'd2, 32'h0000_0000);
    rd(4'd2, d); chk("R6 write0 keeps srst", d, 32'h100);
    @(negedge clk); reset_done = 1; @(negedge clk); reset_done = 0;
    rd(4'd2, d); chk("R6 released", d, 32'h000);
    wr(4'd2, 32'h0000_0010);
    rd(4'd2, d); chk("R2 bit4 reads zero", d, 0);

    // R3 divider sweep
    for (int v = 0; v < 2048; v++) begin
      wr(4'd3, 32'(v) | 32'hFFFF_F800);
      chk("R3 lo pin", 32'(scl_lo_div), 32'(v & 'h3FF));
      rd(4'd3, d); chk("R3 lo read", d, 32'(v & 'h3FF));
    end
    wr(4'd4, 32'h0000_0555);
    rd(4'd4, d); chk("R3 hi read", d, 32'h155);
    chk("R3 hi pin", 32'(scl_hi_div), 32'h155);

    // R4 status live-bit sweep
    for (int c = 0; c < 512; c++) begin
      @(negedge clk);
      eng_nack = c[0]; eng_data_req = c[1]; eng_active = c[2]; scl_in = c[3];
      sda_in = c[4]; rx_full = c[5]; rx_valid = c[6]; tx_ready = c[7]; tx_empty = c[8];
      rd(4'd1, d);
      chk("R4 status", d, (32'(c[0]) << 2) | (32'(c[1]) << 3) | (32'(c[2]) << 5) |
          (32'(c[3]) << 6) | (32'(c[4]) << 7) | (32'(c[5]) << 8) | (32'(!c[6]) << 9) |
          (32'(!c[7]) << 10) | (32'(c[8]) << 11));
    end
    @(negedge clk);
    eng_nack = 0; eng_data_req = 0; eng_active = 0; scl_in = 0; sda_in = 0;
    rx_full = 0; rx_valid = 0; tx_ready = 1; tx_empty = 1;

    // R5 sticky events
    pulse_events(1, 0);
    rd(4'd1, d); chk("R5 done set", d & 3, 1);
    wr(4'd1, 32'h2);
    rd(4'd1, d); chk("R5 other bit clear keeps", d & 3, 1);
    wr(4'd1, 32'h0);
    rd(4'd1, d); chk("R5 write0 keeps", d & 3, 1);
    wr(4'd1, 32'h1);
    rd(4'd1, d); chk("R5 w1c done", d & 3, 0);
    pulse_events(0, 1);
    rd(4'd1, d); chk("R5 arb set", d & 3, 2);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = 4'd1; bus_wdata = 32'h3;
    evt_arb_lost = 1;
    @(negedge clk); bus_valid = 0; bus_write = 0; evt_arb_lost = 0;
    rd(4'd1, d); chk("R5 event beats clear", d & 3, 2);
    wr(4'd1, 32'h3);
    rd(4'd1, d); chk("R5 both clear", d & 3, 0);

    // R7 interrupt sweep over all conditions and enables
    for (int c = 0; c < 128; c++) begin
      wr(4'd2, 32'h0);
      wr(4'd1, 32'h3);
      if (c[0] || c[1]) pulse_events(c[0], c[1]);
      @(negedge clk);
      eng_nack = c[2]; eng_data_req = c[3]; rx_valid = c[4]; rx_full = c[5]; tx_ready = !c[6];
      for (int e = 0; e < 128; e++) begin
        wr(4'd2, {23'd0, 1'b0, e[6:4], 1'b0, e[3:0]});
        chk("R7 irq", 32'(irq), 32'(|(e[6:0] & c[6:0])));
      end
    end
    wr(4'd2, 32'h0);
    wr(4'd1, 32'h3);
    @(negedge clk);
    eng_nack = 0; eng_data_req = 0; rx_valid = 0; rx_full = 0; tx_ready = 1;

    // R8 transmit push and drop
    p0 = push_cnt;
    wr(4'd0, 32'h0000_01A5);
    chk("R8 push count", 32'(push_cnt), 32'(p0 + 1));
    chk("R8 push data", 32'(last_push), 32'hA5);
    @(negedge clk); tx_ready = 0;
    wr(4'd0, 32'h0000_005A);
    chk("R8 drop when full", 32'(push_cnt), 32'(p0 + 1));
    @(negedge clk); tx_ready = 1;

    // R9 receive pop and empty read
    q0 = pop_cnt;
    @(negedge clk); rx_valid = 1; rx_data = 8'h3C;
    rd(4'd0, d); chk("R9 pop data", d, 32'h3C);
    chk("R9 pop count", 32'(pop_cnt), 32'(q0 + 1));
    @(negedge clk); rx_valid = 0; rx_data = 8'hEE;
    rd(4'd0, d); chk("R9 empty read", d, 0);
    chk("R9 no pop", 32'(pop_cnt), 32'(q0 + 1));

    // R10 levels
    @(negedge clk); rx_level = 5'd17; tx_level = 5'd9;
    rd(4'd6, d); chk("R10 rx level", d, 17);
    rd(4'd7, d); chk("R10 tx level", d, 9);

    // R11 unmapped words
    wr(4'd2, 32'h0000_0005);
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, d); chk("R11 unmapped read", d, 0);
    rd(4'd2, d); chk("R11 unmapped write ignored", d, 32'h5);
    wr(4'd15, 32'hFFFF_FFFF);
    rd(4'd15, d); chk("R11 high unmapped", d, 0);
    rd(4'd3, d); chk("R11 divider untouched", d, 32'h3FF);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule